// File: doc/BRIEF.md
# Decoded micro-op cache

This block keeps the decoder's output for recently fetched code so that the front end can skip decoding. Each entry belongs to one aligned 32-byte window of instruction bytes. Entries are found by the virtual fetch address alone, with no translation step. The store is set-associative. Address bits 4:0 select a byte inside the window and are ignored. The bits above them pick the set, and the remaining upper bits form the tag.

One window takes one, two or three ways of its set. Each way holds up to six micro-ops. The front end offers a lookup and gets a hit or miss answer. On a hit the block streams the window's ways in program order, one per output handshake. On a miss the decoder later writes the whole decode result through the fill port in a single cycle. A window that decodes into more than eighteen micro-ops is never stored, so it keeps being served by the decoder. A single-cycle flush input drops every entry.

Top module: `uop_window_cache`

## Requirements
- R1: A lookup is taken on a clock edge where `lk_valid_i` and `lk_ready_o` are both high. Exactly one cycle later, `resp_valid_o` pulses for one cycle. `resp_hit_o` is high only when every way of the addressed window is present. Addresses that differ only in bits 4:0 belong to the same window.
- R2: A hit starts a stream in the same cycle as the response. `out_valid_o` stays high for one beat per way. `out_seq_o` counts 0, 1, 2 in program order. `out_last_o` marks the final beat. `lk_ready_o` is low while the stream is running.
- R3: Beat k carries micro-ops 6k through 6k+5 of the window. Slot s occupies `out_uops_o[16s+15:16s]`. `out_cnt_o` equals min(6, total − 6k). Slots at or above the count read as zero.
- R4: While `out_valid_o` is high and `out_ready_i` is low, the beat (sequence number, count and data) is held unchanged.
- R5: A fill with a total of 1 to 18 micro-ops installs ceil(total/6) ways. Micro-op j is taken from `fill_uops_i[16j+15:16j]`. A later lookup of that window hits with the same data.
- R6: A fill with a total of 0 or above 18 installs nothing. It also removes any copy of that window already held, so later lookups of the window miss.
- R7: A fill first invalidates every way already tagged with the same window, so only the new decode result is returned afterwards.
- R8: Fill ways are chosen by priority. Invalid ways come first. After them come valid ways with the largest age, and ties go to the lowest way index. Each way has a 3-bit age. A filled or hit way gets age 0, and the other valid ways of that set go up by one, stopping at 7.
- R9: If a window has lost one of its ways to replacement, lookups of that window miss.
- R10: While `inval_all_i` is high, every entry is cleared by the next edge and any running stream stops. A lookup taken in that cycle answers miss, and a fill in that cycle is ignored.
- R11: After reset, `lk_ready_o` is high, `resp_valid_o` and `out_valid_o` are low, and all entries are invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inval_all_i | input | 1 | Drop every cached window |
| lk_valid_i | input | 1 | Lookup request |
| lk_addr_i | input | 32 | Virtual fetch address of the lookup |
| lk_ready_o | output | 1 | Lookup can be taken (no stream running) |
| resp_valid_o | output | 1 | Lookup answer valid |
| resp_hit_o | output | 1 | Lookup answer is a hit |
| fill_valid_i | input | 1 | Install a decoded window |
| fill_addr_i | input | 32 | Virtual address of the filled window |
| fill_total_i | input | 6 | Number of micro-ops the decoder produced |
| fill_uops_i | input | 288 | Up to 18 micro-ops, 16 bits each |
| out_valid_o | output | 1 | Stream beat valid |
| out_ready_i | input | 1 | Consumer takes the beat |
| out_seq_o | output | 2 | Sequence number of the way in the beat |
| out_last_o | output | 1 | Final beat of the window |
| out_cnt_o | output | 3 | Valid micro-ops in the beat |
| out_uops_o | output | 96 | Six micro-op slots |

## Verification
Inputs change on the falling edge. Every result is read on the next falling edge after the rising edge that takes effect. The response and beat 0 are read one edge after the lookup is taken. Each later beat is read one edge after the previous beat was accepted. A fill or a flush is visible to a lookup taken on the following edge. A held beat is read again on each stalled cycle. Replacement is checked through hits and misses only: fills and lookups are ordered in a set so that the age arithmetic fixes exactly which window must be gone.

// File: rtl/uopc_pkg.sv
package uopc_pkg;

  // Number of ways a window of 'total' micro-ops needs; 0 when it cannot be stored.
  function automatic int ways_for(input int total, input int per_way, input int max_ways);
    int n;
    n = (total + per_way - 1) / per_way;
    if (total <= 0 || n > max_ways) return 0;
    return n;
  endfunction

  // Micro-ops held by the way with sequence number 'seq'.
  function automatic int slots_in_way(input int total, input int seq, input int per_way);
    int rem;
    if (total <= seq * per_way) return 0;
    rem = total - seq * per_way;
    return (rem > per_way) ? per_way : rem;
  endfunction

  typedef enum logic { ST_IDLE = 1'b0, ST_STREAM = 1'b1 } stream_state_e;

endpackage

// File: rtl/uopc_tag_match.sv
module uopc_tag_match #(
  parameter int WAYS  = 8,
  parameter int TAG_W = 24,
  parameter int NW_W  = 2
) (
  input  logic [WAYS-1:0]       vld_i,
  input  logic [WAYS*TAG_W-1:0] tags_i,
  input  logic [WAYS*NW_W-1:0]  nws_i,
  input  logic [TAG_W-1:0]      tag_i,
  output logic [WAYS-1:0]       match_o,
  output logic [NW_W-1:0]       nw_o,
  output logic                  complete_o
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match_o[w] = vld_i[w] && (tags_i[w*TAG_W +: TAG_W] == tag_i);
  end

  always_comb begin
    nw_o = '0;
    for (int w = 0; w < WAYS; w++)
      if (match_o[w]) nw_o = nw_o | nws_i[w*NW_W +: NW_W];
  end

  // complete only if every way the window was installed with is still there
  assign complete_o = (|match_o) && ($countones(match_o) == int'(nw_o));
endmodule

// File: rtl/uopc_victim_sel.sv
module uopc_victim_sel #(
  parameter int WAYS  = 8,
  parameter int AGE_W = 3,
  parameter int PICKS = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [WAYS-1:0]       free_i,
  input  logic [WAYS*AGE_W-1:0] age_i,
  output logic [PICKS*WAYS-1:0] pick_oh_o
);
  logic [WAYS-1:0] taken;
  logic [AGE_W:0]  pri;
  logic [AGE_W:0]  best_pri;
  logic            found;
  int              best;

  always_comb begin
    taken     = '0;
    pick_oh_o = '0;
    pri       = '0;
    best_pri  = '0;
    found     = 1'b0;
    best      = 0;
    for (int p = 0; p < PICKS; p++) begin
      found    = 1'b0;
      best     = 0;
      best_pri = '0;
      for (int w = 0; w < WAYS; w++) begin
        pri = {free_i[w], age_i[w*AGE_W +: AGE_W]};
        if (!taken[w] && (!found || pri > best_pri)) begin
          found    = 1'b1;
          best     = w;
          best_pri = pri;
        end
      end
      pick_oh_o[p*WAYS + best] = 1'b1;
      taken[best]              = 1'b1;
    end
  end

  // R8
  picks_distinct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pick_oh_o) == PICKS);
endmodule

// File: rtl/uopc_stream.sv
module uopc_stream
  import uopc_pkg::*;
#(
  parameter int WAYS  = 8,
  parameter int SEQ_W = 2,
  parameter int NW_W  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  accept_i,
  input  logic                  hit_i,
  input  logic [WAYS-1:0]       match_i,
  input  logic [NW_W-1:0]       nw_i,
  input  logic [WAYS*SEQ_W-1:0] seqs_i,
  input  logic                  out_ready_i,
  input  logic                  flush_i,
  output logic                  resp_valid_o,
  output logic                  resp_hit_o,
  output logic                  busy_o,
  output logic                  out_valid_o,
  output logic [WAYS-1:0]       sel_oh_o,
  output logic [SEQ_W-1:0]      cur_o,
  output logic                  last_o
);
  stream_state_e    st_q;
  logic [WAYS-1:0]  mask_q;
  logic [NW_W-1:0]  nw_q;
  logic [SEQ_W-1:0] cur_q;

  assign busy_o      = (st_q == ST_STREAM);
  assign out_valid_o = busy_o;
  assign cur_o       = cur_q;
  assign last_o      = busy_o && ((NW_W'(cur_q) + NW_W'(1)) == nw_q);

  for (genvar w = 0; w < WAYS; w++) begin : g_sel
    assign sel_oh_o[w] = busy_o && mask_q[w] && (seqs_i[w*SEQ_W +: SEQ_W] == cur_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q         <= ST_IDLE;
      resp_valid_o <= 1'b0;
      resp_hit_o   <= 1'b0;
      mask_q       <= '0;
      nw_q         <= '0;
      cur_q        <= '0;
    end else begin
      resp_valid_o <= accept_i;
      resp_hit_o   <= accept_i && hit_i;
      if (flush_i) begin
        st_q <= ST_IDLE;
      end else begin
        case (st_q)
          ST_IDLE: if (accept_i && hit_i) begin
            st_q   <= ST_STREAM;
            mask_q <= match_i;
            nw_q   <= nw_i;
            cur_q  <= '0;
          end
          ST_STREAM: if (out_ready_i) begin
            if (last_o) st_q <= ST_IDLE;
            else        cur_q <= cur_q + SEQ_W'(1);
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  // R2
  stream_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_hit_o |-> (out_valid_o && cur_o == '0));
  // R2
  one_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> $onehot(sel_oh_o));
  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_ready_i && !last_o && !flush_i) |=>
      (out_valid_o && cur_o == $past(cur_o) + SEQ_W'(1)));
  // R4
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i && !flush_i) |=>
      (out_valid_o && $stable(cur_o) && $stable(sel_oh_o)));
endmodule

// File: rtl/uop_window_cache.sv
module uop_window_cache
  import uopc_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int SETS      = 8,
  parameter int WAYS      = 8,
  parameter int UPW       = 6,
  parameter int WIN_WAYS  = 3,
  parameter int UOP_W     = 16,
  parameter int WIN_BYTES = 32,
  parameter int AGE_W     = 3,
  localparam int MAXU     = UPW * WIN_WAYS,
  localparam int TOT_W    = $clog2(MAXU + 1) + 1,
  localparam int SEQ_W    = (WIN_WAYS > 1) ? $clog2(WIN_WAYS) : 1,
  localparam int CNT_W    = $clog2(UPW + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   inval_all_i,
  input  logic                   lk_valid_i,
  input  logic [VA_W-1:0]        lk_addr_i,
  output logic                   lk_ready_o,
  output logic                   resp_valid_o,
  output logic                   resp_hit_o,
  input  logic                   fill_valid_i,
  input  logic [VA_W-1:0]        fill_addr_i,
  input  logic [TOT_W-1:0]       fill_total_i,
  input  logic [MAXU*UOP_W-1:0]  fill_uops_i,
  output logic                   out_valid_o,
  input  logic                   out_ready_i,
  output logic [SEQ_W-1:0]       out_seq_o,
  output logic                   out_last_o,
  output logic [CNT_W-1:0]       out_cnt_o,
  output logic [UPW*UOP_W-1:0]   out_uops_o
);
  localparam int OFF_W  = $clog2(WIN_BYTES);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = VA_W - OFF_W - IDX_W;
  localparam int NW_W   = $clog2(WIN_WAYS + 1);
  localparam int LINE_W = UPW * UOP_W;
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  // ---------------- storage ----------------
  logic [WAYS-1:0]   vld_q [SETS];
  logic [AGE_W-1:0]  age_q [SETS][WAYS];
  logic [TAG_W-1:0]  tag_q [SETS][WAYS];
  logic [SEQ_W-1:0]  seq_q [SETS][WAYS];
  logic [NW_W-1:0]   nw_q  [SETS][WAYS];
  logic [CNT_W-1:0]  cnt_q [SETS][WAYS];
  logic [LINE_W-1:0] dat_q [SETS][WAYS];
  logic [IDX_W-1:0]  str_idx_q;

  // ---------------- address split ----------------
  logic [IDX_W-1:0] lk_idx, f_idx;
  logic [TAG_W-1:0] lk_tag, f_tag;
  logic             unused_offset_bits;
  assign lk_idx = lk_addr_i[OFF_W +: IDX_W];
  assign lk_tag = lk_addr_i[OFF_W + IDX_W +: TAG_W];
  assign f_idx  = fill_addr_i[OFF_W +: IDX_W];
  assign f_tag  = fill_addr_i[OFF_W + IDX_W +: TAG_W];
  assign unused_offset_bits = ^{lk_addr_i[OFF_W-1:0], fill_addr_i[OFF_W-1:0]};

  // ---------------- flattened set views ----------------
  logic [WAYS*TAG_W-1:0] lk_tags, f_tags;
  logic [WAYS*NW_W-1:0]  lk_nws, f_nws;
  logic [WAYS*AGE_W-1:0] f_ages;
  logic [WAYS*SEQ_W-1:0] str_seqs;
  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      lk_tags[w*TAG_W +: TAG_W]  = tag_q[lk_idx][w];
      lk_nws[w*NW_W +: NW_W]     = nw_q[lk_idx][w];
      f_tags[w*TAG_W +: TAG_W]   = tag_q[f_idx][w];
      f_nws[w*NW_W +: NW_W]      = nw_q[f_idx][w];
      f_ages[w*AGE_W +: AGE_W]   = age_q[f_idx][w];
      str_seqs[w*SEQ_W +: SEQ_W] = seq_q[str_idx_q][w];
    end
  end

  // ---------------- lookup side ----------------
  logic [WAYS-1:0] lk_match;
  logic [NW_W-1:0] lk_nw;
  logic            lk_complete, lk_hit, accept, busy;

  uopc_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W), .NW_W(NW_W)) u_lk_match (
    .vld_i(vld_q[lk_idx]), .tags_i(lk_tags), .nws_i(lk_nws), .tag_i(lk_tag),
    .match_o(lk_match), .nw_o(lk_nw), .complete_o(lk_complete));

  assign lk_ready_o = !busy;
  assign accept     = lk_valid_i && lk_ready_o;
  assign lk_hit     = lk_complete && !inval_all_i;

  // ---------------- fill side ----------------
  logic [WAYS-1:0]       f_match, f_free, f_touch;
  logic [NW_W-1:0]       f_nw_unused;
  logic                  f_complete_unused;
  logic [WIN_WAYS*WAYS-1:0] f_pick;
  logic                  f_ok;
  int                    f_need;

  uopc_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W), .NW_W(NW_W)) u_fill_match (
    .vld_i(vld_q[f_idx]), .tags_i(f_tags), .nws_i(f_nws), .tag_i(f_tag),
    .match_o(f_match), .nw_o(f_nw_unused), .complete_o(f_complete_unused));

  assign f_ok   = fill_valid_i && !inval_all_i;
  assign f_need = ways_for(int'(fill_total_i), UPW, WIN_WAYS);
  assign f_free = ~vld_q[f_idx] | f_match;

  uopc_victim_sel #(.WAYS(WAYS), .AGE_W(AGE_W), .PICKS(WIN_WAYS)) u_victim (
    .clk(clk), .rst_n(rst_n), .free_i(f_free), .age_i(f_ages), .pick_oh_o(f_pick));

  always_comb begin
    f_touch = '0;
    for (int p = 0; p < WIN_WAYS; p++)
      if (p < f_need) f_touch = f_touch | f_pick[p*WAYS +: WAYS];
  end

  function automatic logic [AGE_W-1:0] age_next(input logic touch, input logic valid,
                                                 input logic [AGE_W-1:0] age);
    if (touch) return '0;
    if (valid && age != AGE_MAX) return age + AGE_W'(1);
    return age;
  endfunction

  // ---------------- valid bits and ages ----------------
  logic hit_touch;
  assign hit_touch = accept && lk_hit && !f_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= '0;
      end
      str_idx_q <= '0;
    end else begin
      if (accept) str_idx_q <= lk_idx;
      if (inval_all_i) begin
        for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
      end else if (f_ok) begin
        vld_q[f_idx] <= (vld_q[f_idx] & ~f_match) | f_touch;
        if (f_need > 0)
          for (int w = 0; w < WAYS; w++)
            age_q[f_idx][w] <= age_next(f_touch[w], vld_q[f_idx][w] && !f_match[w],
                                        age_q[f_idx][w]);
      end else if (hit_touch) begin
        for (int w = 0; w < WAYS; w++)
          age_q[lk_idx][w] <= age_next(lk_match[w], vld_q[lk_idx][w], age_q[lk_idx][w]);
      end
    end
  end

  // ---------------- way payload ----------------
  always_ff @(posedge clk) begin
    if (f_ok) begin
      for (int p = 0; p < WIN_WAYS; p++) begin
        if (p < f_need) begin
          for (int w = 0; w < WAYS; w++) begin
            if (f_pick[p*WAYS + w]) begin
              tag_q[f_idx][w] <= f_tag;
              seq_q[f_idx][w] <= SEQ_W'(p);
              nw_q[f_idx][w]  <= NW_W'(f_need);
              cnt_q[f_idx][w] <= CNT_W'(slots_in_way(int'(fill_total_i), p, UPW));
              dat_q[f_idx][w] <= fill_uops_i[p*LINE_W +: LINE_W];
            end
          end
        end
      end
    end
  end

  // ---------------- output stream ----------------
  logic [WAYS-1:0]   sel_oh;
  logic [CNT_W-1:0]  sel_cnt;
  logic [LINE_W-1:0] sel_dat;

  uopc_stream #(.WAYS(WAYS), .SEQ_W(SEQ_W), .NW_W(NW_W)) u_stream (
    .clk(clk), .rst_n(rst_n), .accept_i(accept), .hit_i(lk_hit), .match_i(lk_match),
    .nw_i(lk_nw), .seqs_i(str_seqs), .out_ready_i(out_ready_i), .flush_i(inval_all_i),
    .resp_valid_o(resp_valid_o), .resp_hit_o(resp_hit_o), .busy_o(busy),
    .out_valid_o(out_valid_o), .sel_oh_o(sel_oh), .cur_o(out_seq_o), .last_o(out_last_o));

  always_comb begin
    sel_cnt = '0;
    sel_dat = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (sel_oh[w]) begin
        sel_cnt = sel_cnt | cnt_q[str_idx_q][w];
        sel_dat = sel_dat | dat_q[str_idx_q][w];
      end
    end
  end

  assign out_cnt_o = sel_cnt;
  always_comb begin
    for (int s = 0; s < UPW; s++)
      out_uops_o[s*UOP_W +: UOP_W] = (s < int'(sel_cnt)) ? sel_dat[s*UOP_W +: UOP_W] : '0;
  end

  // ---------------- checks ----------------
  logic any_vld;
  always_comb begin
    any_vld = 1'b0;
    for (int s = 0; s < SETS; s++) any_vld = any_vld | (|vld_q[s]);
  end

  // R10
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inval_all_i |=> (!any_vld && !out_valid_o));
  // R2
  no_lookup_in_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> !lk_ready_o);
  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> (out_cnt_o != '0 && int'(out_cnt_o) <= UPW));
endmodule

// File: tb/sim_uop_window_cache.sv
`timescale 1ns/1ps
module sim_uop_window_cache;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         inval_all_i = 1'b0;
  logic         lk_valid_i = 1'b0;
  logic [31:0]  lk_addr_i = '0;
  logic         lk_ready_o;
  logic         resp_valid_o, resp_hit_o;
  logic         fill_valid_i = 1'b0;
  logic [31:0]  fill_addr_i = '0;
  logic [5:0]   fill_total_i = '0;
  logic [287:0] fill_uops_i = '0;
  logic         out_valid_o;
  logic         out_ready_i = 1'b1;
  logic [1:0]   out_seq_o;
  logic         out_last_o;
  logic [2:0]   out_cnt_o;
  logic [95:0]  out_uops_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uop_window_cache u0 (
    .clk(clk), .rst_n(rst_n), .inval_all_i(inval_all_i),
    .lk_valid_i(lk_valid_i), .lk_addr_i(lk_addr_i), .lk_ready_o(lk_ready_o),
    .resp_valid_o(resp_valid_o), .resp_hit_o(resp_hit_o),
    .fill_valid_i(fill_valid_i), .fill_addr_i(fill_addr_i),
    .fill_total_i(fill_total_i), .fill_uops_i(fill_uops_i),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .out_seq_o(out_seq_o),
    .out_last_o(out_last_o), .out_cnt_o(out_cnt_o), .out_uops_o(out_uops_o));

  function automatic logic [31:0] wa(input int tag, input int set, input int off);
    return (32'(tag) << 8) | (32'(set) << 5) | 32'(off);
  endfunction

  task automatic chk(input string rq, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic fill(input logic [31:0] a, input int total, input int base);
    @(negedge clk);
    fill_valid_i = 1'b1;
    fill_addr_i  = a;
    fill_total_i = 6'(total);
    for (int j = 0; j < 18; j++) fill_uops_i[j*16 +: 16] = 16'(base + j);
    @(negedge clk);
    fill_valid_i = 1'b0;
  endtask

  task automatic check_beat(input string rq, input int k, input int total, input int base);
    int nw, cnt;
    nw  = (total + 5) / 6;
    cnt = (total - 6*k > 6) ? 6 : total - 6*k;
    chk(rq, "out_valid", 64'(out_valid_o), 1);
    chk(rq, "out_seq", 64'(out_seq_o), 64'(k));
    chk(rq, "out_last", 64'(out_last_o), 64'(k == nw - 1));
    chk("R3", "out_cnt", 64'(out_cnt_o), 64'(cnt));
    for (int s = 0; s < 6; s++)
      chk("R3", $sformatf("beat %0d slot %0d", k, s), 64'(out_uops_o[s*16 +: 16]),
          (s < cnt) ? 64'(16'(base + 6*k + s)) : 64'd0);
  endtask

  // Issues a lookup and checks the answer and, on a hit, the whole stream.
  task automatic lookup(input string rq, input logic [31:0] a, input bit exp_hit,
                        input int total, input int base, input int stall);
    int nw;
    @(negedge clk);
    lk_valid_i = 1'b1;
    lk_addr_i  = a;
    @(negedge clk);
    lk_valid_i = 1'b0;
    chk("R1", "resp_valid", 64'(resp_valid_o), 1);
    chk(rq, "resp_hit", 64'(resp_hit_o), 64'(exp_hit));
    if (exp_hit) begin
      nw = (total + 5) / 6;
      for (int k = 0; k < nw; k++) begin
        check_beat("R2", k, total, base);
        chk("R2", "lk_ready in stream", 64'(lk_ready_o), 0);
        if (k == 0) begin
          for (int i = 0; i < stall; i++) begin
            out_ready_i = 1'b0;
            @(negedge clk);
            check_beat("R4", k, total, base);
          end
        end
        out_ready_i = 1'b1;
        @(negedge clk);
      end
      chk("R2", "stream ended", 64'(out_valid_o), 0);
    end else begin
      chk(rq, "no stream on miss", 64'(out_valid_o), 0);
      @(negedge clk);
    end
    chk("R1", "resp pulse one cycle", 64'(resp_valid_o), 0);
    chk("R2", "lk_ready after", 64'(lk_ready_o), 1);
  endtask

  task automatic t_reset;
    chk("R11", "lk_ready", 64'(lk_ready_o), 1);
    chk("R11", "resp_valid", 64'(resp_valid_o), 0);
    chk("R11", "out_valid", 64'(out_valid_o), 0);
    lookup("R11", wa(1, 0, 0), 0, 0, 0, 0);
  endtask

  task automatic t_single;
    fill(wa(1, 0, 0), 4, 100);
    lookup("R5", wa(1, 0, 9), 1, 4, 100, 0);
    lookup("R1", wa(9, 0, 0), 0, 0, 0, 0);
  endtask

  task automatic t_multi;
    fill(wa(2, 1, 0), 13, 200);
    lookup("R5", wa(2, 1, 31), 1, 13, 200, 2);
    fill(wa(3, 2, 0), 18, 250);
    lookup("R5", wa(3, 2, 4), 1, 18, 250, 0);
  endtask

  task automatic t_overflow;
    fill(wa(4, 4, 0), 6, 300);
    lookup("R5", wa(4, 4, 0), 1, 6, 300, 0);
    fill(wa(4, 4, 0), 19, 350);
    lookup("R6", wa(4, 4, 0), 0, 0, 0, 0);
    fill(wa(4, 4, 0), 0, 360);
    lookup("R6", wa(4, 4, 0), 0, 0, 0, 0);
  endtask

  task automatic t_refill;
    fill(wa(5, 6, 0), 18, 400);
    fill(wa(5, 6, 0), 5, 500);
    lookup("R7", wa(5, 6, 0), 1, 5, 500, 0);
  endtask

  task automatic t_lru;
    for (int t = 10; t < 18; t++) fill(wa(t, 3, 0), 1, t * 10);
    lookup("R8", wa(10, 3, 0), 1, 1, 100, 0);
    fill(wa(18, 3, 0), 1, 180);
    lookup("R8", wa(11, 3, 0), 0, 0, 0, 0);
    lookup("R8", wa(10, 3, 0), 1, 1, 100, 0);
    lookup("R8", wa(12, 3, 0), 1, 1, 120, 0);
    lookup("R8", wa(18, 3, 0), 1, 1, 180, 0);
  endtask

  task automatic t_partial;
    fill(wa(20, 5, 0), 18, 600);
    for (int t = 21; t < 27; t++) fill(wa(t, 5, 0), 1, t * 10);
    lookup("R9", wa(20, 5, 0), 0, 0, 0, 0);
    lookup("R9", wa(26, 5, 0), 1, 1, 260, 0);
  endtask

  task automatic t_inval;
    fill(wa(6, 7, 0), 18, 700);
    @(negedge clk);
    lk_valid_i = 1'b1;
    lk_addr_i  = wa(6, 7, 0);
    @(negedge clk);
    lk_valid_i = 1'b0;
    chk("R10", "hit before flush", 64'(resp_hit_o), 1);
    out_ready_i = 1'b0;
    inval_all_i = 1'b1;
    @(negedge clk);
    inval_all_i = 1'b0;
    out_ready_i = 1'b1;
    chk("R10", "stream aborted", 64'(out_valid_o), 0);
    chk("R10", "lk_ready after abort", 64'(lk_ready_o), 1);
    lookup("R10", wa(6, 7, 0), 0, 0, 0, 0);
    lookup("R10", wa(1, 0, 0), 0, 0, 0, 0);
    // fill in the flush cycle is ignored
    @(negedge clk);
    fill_valid_i = 1'b1;
    fill_addr_i  = wa(7, 7, 0);
    fill_total_i = 6'd3;
    inval_all_i  = 1'b1;
    @(negedge clk);
    fill_valid_i = 1'b0;
    inval_all_i  = 1'b0;
    lookup("R10", wa(7, 7, 0), 0, 0, 0, 0);
    // lookup in the flush cycle answers miss
    fill(wa(8, 7, 0), 2, 800);
    @(negedge clk);
    lk_valid_i  = 1'b1;
    lk_addr_i   = wa(8, 7, 0);
    inval_all_i = 1'b1;
    @(negedge clk);
    lk_valid_i  = 1'b0;
    inval_all_i = 1'b0;
    chk("R10", "resp_valid in flush", 64'(resp_valid_o), 1);
    chk("R10", "resp_hit in flush", 64'(resp_hit_o), 0);
    chk("R10", "no stream in flush", 64'(out_valid_o), 0);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_single;
    t_multi;
    t_overflow;
    t_refill;
    t_lru;
    t_partial;
    t_inval;
    done = 1;
    finish_run;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run;
    end
  end
endmodule